// File: doc/BRIEF.md
# Multi-Level Radix Page Table Walker

This block translates one effective address per request by walking a radix tree of 64-bit entries held in memory. The caller supplies the base address of the top table, the number of index bits that table consumes, the total width of the translated address space and the effective address. The walker then fetches one entry per level over a single-request memory port. Each non-leaf entry names the base and the index width of the table below it, so the index width can change from level to level. The first leaf ends the descent. The walker then reports the real address and the page size, which is the number of address bits no level has consumed.

Once the leaf is found, the walker sets the entry's reference flag, and also its change flag when the access is a store. It writes the entry back only when this actually alters it. A load result withholds write permission, so a later store walks again and marks the page as changed. A bad table shape or an entry without its valid flag ends the walk with a fault. The fault carries one cause bit. A start pulse opens each walk and a one-cycle done pulse closes it.

Top module: `rtw_walker`

## Requirements
- R1: A one-cycle `start` is accepted only while the walker is idle, and a `start` raised during a walk has no effect on that walk. Each walk ends with `done` high for exactly one cycle, with `mem_req` low in that cycle and the results valid from that cycle until the next accepted start.
- R2: At each level the entry is fetched from byte address base + 8 × ((ea >> (remaining − idx)) & (2^idx − 1)). Here remaining is `total_bits` at the top level and idx is that level's index width. Every request address is 8-byte aligned.
- R3: An index width below 5, or one larger than the remaining bit count, ends the walk with `fault`=1 and `cause`=2'b01 (configuration). This applies to the top level and to every lower level. No further memory access follows, and a bad top level makes no memory access at all.
- R4: An entry with bit 63 (valid) clear ends the walk with `fault`=1 and `cause`=2'b10 (no entry). A walk that ends without a fault reports `cause`=2'b00.
- R5: An entry with bit 62 (leaf) clear is a directory entry. Its bits [4:0] give the next index width and its bits [55:8] (with bits [7:0] zero) give the next table base. The remaining bit count drops by the current level's index width after every entry read.
- R6: At a leaf, `page_bits` equals the remaining bit count. `raddr` is entry bits [55:12] in place (all other bits zero), with the low `page_bits` bits cleared, ORed with the low `page_bits` bits of the effective address. Effective-address bits above `total_bits` have no effect.
- R7: The updated leaf always has bit 8 (reference) set and has bit 7 (change) set for a store. `wr_ok` equals `is_store`, so a load never grants write permission.
- R8: The updated leaf is written back to the leaf's own address only when it differs from the entry that was read. When it does not differ, no memory write occurs.
- R9: At most 8 entries are read per walk. A directory entry found in the 8th read ends the walk with the configuration cause.
- R10: The memory port has at most one request outstanding. `mem_req`, `mem_we` and `mem_addr` stay steady from the cycle a request is raised until the cycle `mem_ack` is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a walk (sampled when idle) |
| is_store | input | 1 | Access is a store |
| ea | input | 64 | Effective address |
| root_base | input | 64 | Byte address of the top-level table |
| root_idx_bits | input | 5 | Index width of the top-level table |
| total_bits | input | 7 | Width of the translated address space |
| done | output | 1 | One-cycle end-of-walk pulse |
| fault | output | 1 | Walk ended in a fault |
| cause | output | 2 | Fault cause: bit 0 configuration, bit 1 no entry |
| raddr | output | 64 | Translated real address |
| page_bits | output | 7 | log2 of the page size |
| wr_ok | output | 1 | Write permission granted by this walk |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | 64 | Request byte address |
| mem_wdata | output | 64 | Write data |
| mem_ack | input | 1 | Request accepted; read data valid |
| mem_rdata | input | 64 | Read data |

## Verification
A wrong remaining-count or index-width register shows up as a wrong fetch address, which is caught at the very next request. Failing that, it surfaces as a wrong `page_bits` or `raddr` at `done` of the same walk. A wrong level counter shows up as a wrong number of reads before a depth fault. A bad comparison of old and new entry shows up as a missing or extra write, which the memory model counts per walk, and a lost flag shows up in the stored image. Each fault class is provoked at the top level and at a lower level.

// File: rtl/rtw_pkg.sv
package rtw_pkg;
   localparam int ENT_W       = 64;
   localparam int VALID_BIT   = 63;
   localparam int LEAF_BIT    = 62;
   localparam int REF_BIT     = 8;
   localparam int CHG_BIT     = 7;
   localparam int IDXF_W      = 5;
   localparam int CAUSE_W     = 2;
   localparam int CS_CFG      = 0;
   localparam int CS_NOENT    = 1;
   localparam logic [ENT_W-1:0] BASE_MASK = 64'h00FF_FFFF_FFFF_FF00;
   localparam logic [ENT_W-1:0] PFN_MASK  = 64'h00FF_FFFF_FFFF_F000;

   typedef enum logic [1:0] {
      ST_IDLE,
      ST_READ,
      ST_WBACK,
      ST_DONE
   } walk_state_e;
endpackage

// File: rtl/rtw_index.sv
module rtw_index #(
   parameter int EA_W    = 64,
   parameter int ADDR_W  = 64,
   parameter int SZ_W    = 7,
   parameter int IDX_W   = 5,
   parameter int MIN_IDX = 5
) (
   input  logic [ADDR_W-1:0] base,
   input  logic [EA_W-1:0]   ea,
   input  logic [SZ_W-1:0]   rem,
   input  logic [IDX_W-1:0]  idx_bits,
   output logic [ADDR_W-1:0] ent_addr,
   output logic              bad
);
   logic [SZ_W-1:0]   idx_ext;
   logic [SZ_W-1:0]   shamt;
   logic [EA_W-1:0]   slot;
   logic [EA_W-1:0]   off;
   logic [ADDR_W-1:0] off_a;

   assign idx_ext = {{(SZ_W-IDX_W){1'b0}}, idx_bits};
   assign bad     = (idx_bits < IDX_W'(MIN_IDX)) || (idx_ext > rem);
   assign shamt   = rem - idx_ext;
   assign slot    = (ea >> shamt) & ~({EA_W{1'b1}} << idx_bits);
   assign off     = slot << 3;

   generate
      if (ADDR_W >= EA_W) begin : g_widen
         assign off_a = {{(ADDR_W-EA_W){1'b0}}, off};
      end else begin : g_narrow
         assign off_a = off[ADDR_W-1:0];
      end
   endgenerate

   assign ent_addr = base + off_a;
endmodule

// File: rtl/rtw_leaf.sv
module rtw_leaf #(
   parameter int EA_W   = 64,
   parameter int ADDR_W = 64,
   parameter int SZ_W   = 7
) (
   input  logic [rtw_pkg::ENT_W-1:0] entry,
   input  logic [EA_W-1:0]           ea,
   input  logic [SZ_W-1:0]           psize,
   input  logic                      is_store,
   output logic [ADDR_W-1:0]         raddr,
   output logic [rtw_pkg::ENT_W-1:0] new_ent,
   output logic                      changed
);
   import rtw_pkg::*;

   logic [ENT_W-1:0] ea64;
   logic [ENT_W-1:0] low;
   logic [ENT_W-1:0] full;
   logic [ENT_W-1:0] flags;

   generate
      if (EA_W < ENT_W) begin : g_pad
         assign ea64 = {{(ENT_W-EA_W){1'b0}}, ea};
      end else begin : g_same
         assign ea64 = ea;
      end
   endgenerate

   assign low   = ~({ENT_W{1'b1}} << psize);
   assign full  = (entry & PFN_MASK & ~low) | (ea64 & low);
   assign raddr = full[ADDR_W-1:0];

   always_comb begin
      flags          = '0;
      flags[REF_BIT] = 1'b1;
      flags[CHG_BIT] = is_store;
   end

   assign new_ent = entry | flags;
   assign changed = (new_ent != entry);
endmodule

// File: rtl/rtw_walker.sv
module rtw_walker #(
   parameter int EA_W       = 64,
   parameter int ADDR_W     = 64,
   parameter int MAX_LEVELS = 8,
   parameter int MIN_IDX    = 5
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        start,
   input  logic                        is_store,
   input  logic [EA_W-1:0]             ea,
   input  logic [ADDR_W-1:0]           root_base,
   input  logic [rtw_pkg::IDXF_W-1:0]  root_idx_bits,
   input  logic [$clog2(EA_W+1)-1:0]   total_bits,
   output logic                        done,
   output logic                        fault,
   output logic [rtw_pkg::CAUSE_W-1:0] cause,
   output logic [ADDR_W-1:0]           raddr,
   output logic [$clog2(EA_W+1)-1:0]   page_bits,
   output logic                        wr_ok,
   output logic                        mem_req,
   output logic                        mem_we,
   output logic [ADDR_W-1:0]           mem_addr,
   output logic [rtw_pkg::ENT_W-1:0]   mem_wdata,
   input  logic                        mem_ack,
   input  logic [rtw_pkg::ENT_W-1:0]   mem_rdata
);
   import rtw_pkg::*;

   localparam int SZ_W  = $clog2(EA_W+1);
   localparam int IDX_W = IDXF_W;
   localparam int LVL_W = $clog2(MAX_LEVELS+1);

   generate
      if (MAX_LEVELS < 1) begin : g_chk_lvl
         $error("MAX_LEVELS must be at least 1");
      end
      if (MIN_IDX < 1 || MIN_IDX >= (1 << IDX_W)) begin : g_chk_min
         $error("MIN_IDX must fit the index field");
      end
      if (EA_W > ENT_W || ADDR_W > ENT_W) begin : g_chk_w
         $error("address widths must not exceed the entry width");
      end
      if (SZ_W <= IDX_W) begin : g_chk_sz
         $error("EA_W too small for the index field");
      end
   endgenerate

   walk_state_e       state_q;
   logic [EA_W-1:0]   ea_q;
   logic              st_q;
   logic [SZ_W-1:0]   rem_q;
   logic [IDX_W-1:0]  cur_bits_q;
   logic [LVL_W-1:0]  lvl_q;
   logic [ADDR_W-1:0] addr_q;
   logic [ENT_W-1:0]  wdata_q;

   logic              in_idle;
   logic [SZ_W-1:0]   rem_after;
   logic [ADDR_W-1:0] ix_base;
   logic [EA_W-1:0]   ix_ea;
   logic [SZ_W-1:0]   ix_rem;
   logic [IDX_W-1:0]  ix_bits;
   logic [ADDR_W-1:0] ix_addr;
   logic              ix_bad;
   logic [ADDR_W-1:0] lf_raddr;
   logic [ENT_W-1:0]  lf_new;
   logic              lf_changed;

   assign in_idle   = (state_q == ST_IDLE);
   assign rem_after = rem_q - {{(SZ_W-IDX_W){1'b0}}, cur_bits_q};
   assign ix_base   = in_idle ? root_base     : ADDR_W'(mem_rdata & BASE_MASK);
   assign ix_ea     = in_idle ? ea            : ea_q;
   assign ix_rem    = in_idle ? total_bits    : rem_after;
   assign ix_bits   = in_idle ? root_idx_bits : mem_rdata[IDX_W-1:0];

   rtw_index #(
      .EA_W(EA_W), .ADDR_W(ADDR_W), .SZ_W(SZ_W), .IDX_W(IDX_W), .MIN_IDX(MIN_IDX)
   ) u_index (
      .base(ix_base), .ea(ix_ea), .rem(ix_rem), .idx_bits(ix_bits),
      .ent_addr(ix_addr), .bad(ix_bad)
   );

   rtw_leaf #(
      .EA_W(EA_W), .ADDR_W(ADDR_W), .SZ_W(SZ_W)
   ) u_leaf (
      .entry(mem_rdata), .ea(ea_q), .psize(rem_after), .is_store(st_q),
      .raddr(lf_raddr), .new_ent(lf_new), .changed(lf_changed)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q    <= ST_IDLE;
         ea_q       <= '0;
         st_q       <= 1'b0;
         rem_q      <= '0;
         cur_bits_q <= '0;
         lvl_q      <= '0;
         addr_q     <= '0;
         wdata_q    <= '0;
         fault      <= 1'b0;
         cause      <= '0;
         raddr      <= '0;
         page_bits  <= '0;
         wr_ok      <= 1'b0;
      end else begin
         unique case (state_q)
            ST_IDLE: begin
               if (start) begin
                  ea_q      <= ea;
                  st_q      <= is_store;
                  fault     <= 1'b0;
                  cause     <= '0;
                  raddr     <= '0;
                  page_bits <= '0;
                  wr_ok     <= 1'b0;
                  if (ix_bad) begin
                     fault         <= 1'b1;
                     cause[CS_CFG] <= 1'b1;
                     state_q       <= ST_DONE;
                  end else begin
                     addr_q     <= ix_addr;
                     rem_q      <= total_bits;
                     cur_bits_q <= root_idx_bits;
                     lvl_q      <= LVL_W'(1);
                     state_q    <= ST_READ;
                  end
               end
            end
            ST_READ: begin
               if (mem_ack) begin
                  if (!mem_rdata[VALID_BIT]) begin
                     fault           <= 1'b1;
                     cause[CS_NOENT] <= 1'b1;
                     state_q         <= ST_DONE;
                  end else if (mem_rdata[LEAF_BIT]) begin
                     raddr     <= lf_raddr;
                     page_bits <= rem_after;
                     wr_ok     <= st_q;
                     wdata_q   <= lf_new;
                     state_q   <= lf_changed ? ST_WBACK : ST_DONE;
                  end else if (lvl_q == LVL_W'(MAX_LEVELS) || ix_bad) begin
                     fault         <= 1'b1;
                     cause[CS_CFG] <= 1'b1;
                     state_q       <= ST_DONE;
                  end else begin
                     addr_q     <= ix_addr;
                     rem_q      <= rem_after;
                     cur_bits_q <= mem_rdata[IDX_W-1:0];
                     lvl_q      <= lvl_q + LVL_W'(1);
                  end
               end
            end
            ST_WBACK: begin
               if (mem_ack) begin
                  state_q <= ST_DONE;
               end
            end
            ST_DONE: begin
               state_q <= ST_IDLE;
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign done      = (state_q == ST_DONE);
   assign mem_req   = (state_q == ST_READ) || (state_q == ST_WBACK);
   assign mem_we    = (state_q == ST_WBACK);
   assign mem_addr  = addr_q;
   assign mem_wdata = wdata_q;
endmodule

// File: rtl/rtw_walker_chk.sv
module rtw_walker_chk #(
   parameter int ADDR_W = 64
) (
   input logic                        clk,
   input logic                        rst_n,
   input logic                        done,
   input logic                        fault,
   input logic [rtw_pkg::CAUSE_W-1:0] cause,
   input logic                        mem_req,
   input logic                        mem_we,
   input logic                        mem_ack,
   input logic [ADDR_W-1:0]           mem_addr,
   input logic                        wb_ref
);
   AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we)); // R10
   AST_ADDR_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req |-> mem_addr[2:0] == 3'b000); // R2
   AST_WB_REF_SET: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req && mem_we |-> wb_ref); // R7
   AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done); // R1
   AST_DONE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !mem_req); // R1
   AST_ONE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      done && fault |-> $countones(cause) == 1); // R3
   AST_CLEAN_END: assert property (@(posedge clk) disable iff (!rst_n)
      done && !fault |-> cause == '0); // R4
endmodule

bind rtw_walker rtw_walker_chk #(.ADDR_W(ADDR_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .done(done), .fault(fault), .cause(cause),
   .mem_req(mem_req), .mem_we(mem_we), .mem_ack(mem_ack), .mem_addr(mem_addr),
   .wb_ref(mem_wdata[rtw_pkg::REF_BIT])
);

// File: tb/rtw_walker_bench.sv
module rtw_walker_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic        is_store = 1'b0;
   logic [63:0] ea = '0;
   logic [63:0] root_base = '0;
   logic [4:0]  root_idx_bits = 5'd5;
   logic [6:0]  total_bits = 7'd24;
   logic        done, fault, wr_ok, mem_req, mem_we;
   logic [1:0]  cause;
   logic [63:0] raddr, mem_addr, mem_wdata;
   logic [6:0]  page_bits;
   logic        mem_ack = 1'b0;
   logic [63:0] mem_rdata = '0;

   always #2.5 clk = ~clk;

   rtw_walker u_rtw_walker (
      .clk(clk), .rst_n(rst_n), .start(start), .is_store(is_store), .ea(ea),
      .root_base(root_base), .root_idx_bits(root_idx_bits), .total_bits(total_bits),
      .done(done), .fault(fault), .cause(cause), .raddr(raddr), .page_bits(page_bits),
      .wr_ok(wr_ok), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
      .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata)
   );

   // memory model: two-cycle latency, counts reads/writes, flags unsteady requests
   logic [63:0] mem [0:1023];
   int          nrd = 0, nwr = 0, viol = 0, wcnt = 0;
   logic        pend = 1'b0, pwe = 1'b0;
   logic [63:0] paddr = '0, last_rd = '0;

   always @(posedge clk) begin
      if (!rst_n) begin
         mem_ack <= 1'b0; pend <= 1'b0; wcnt <= 0;
      end else if (mem_ack) begin
         mem_ack <= 1'b0; pend <= 1'b0; wcnt <= 0;
      end else if (mem_req) begin
         if (pend && (mem_addr != paddr || mem_we != pwe)) viol <= viol + 1;
         pend <= 1'b1; paddr <= mem_addr; pwe <= mem_we;
         if (wcnt == 1) begin
            mem_ack   <= 1'b1;
            mem_rdata <= mem[mem_addr[12:3]];
            if (mem_we) begin
               mem[mem_addr[12:3]] <= mem_wdata;
               nwr <= nwr + 1;
            end else begin
               nrd <= nrd + 1;
               last_rd <= mem_addr;
            end
         end else begin
            wcnt <= wcnt + 1;
         end
      end
   end

   int checks = 0, errors = 0, cyc = 0;

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (cyc > 100000) begin
         errors = errors + 1;
         $display("FAIL watchdog: run hung, act %0d cycles exp < 100000", cyc);
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
      checks = checks + 1;
      if (act !== exp) begin
         errors = errors + 1;
         $display("FAIL %s act %h exp %h", tag, act, exp);
      end
   endtask

   task automatic walk(input logic [63:0] b, input logic [4:0] ib, input logic [6:0] tb,
                       input logic [63:0] e, input logic s);
      int n;
      @(negedge clk);
      root_base = b; root_idx_bits = ib; total_bits = tb; ea = e; is_store = s;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      n = 0;
      while (!done && n < 1000) begin
         @(negedge clk);
         n++;
      end
      if (n >= 1000) chk("R1 done timeout", 64'd0, 64'd1);
   endtask

   typedef struct packed {
      logic [63:0] ea; logic st; logic flt; logic [1:0] cs;
      logic [63:0] ra; logic [6:0] pg; logic wok; logic [1:0] nw;
   } vec_t;

   // top table at 0x000 (5 index bits, 24-bit space); second level at 0x100 (6 bits)
   localparam vec_t VT [10] = '{
      '{64'h123,              1'b0, 1'b0, 2'b00, 64'hABC123,       7'd13, 1'b0, 2'd1},
      '{64'h456,              1'b0, 1'b0, 2'b00, 64'hABC456,       7'd13, 1'b0, 2'd0},
      '{64'h1FFF,             1'b1, 1'b0, 2'b00, 64'hABDFFF,       7'd13, 1'b1, 2'd1},
      '{64'h2010,             1'b0, 1'b1, 2'b10, 64'h0,            7'd0,  1'b0, 2'd0},
      '{64'h4ABC,             1'b1, 1'b0, 2'b00, 64'h5550ABC,      7'd13, 1'b1, 2'd0},
      '{64'h6000,             1'b0, 1'b1, 2'b01, 64'h0,            7'd0,  1'b0, 2'd0},
      '{64'h0ABCDE,           1'b0, 1'b0, 2'b00, 64'h1234567ABCDE, 7'd19, 1'b0, 2'd1},
      '{64'h100000,           1'b0, 1'b1, 2'b10, 64'h0,            7'd0,  1'b0, 2'd0},
      '{64'h180000,           1'b0, 1'b1, 2'b01, 64'h0,            7'd0,  1'b0, 2'd0},
      '{64'hFF00000000000777, 1'b0, 1'b0, 2'b00, 64'hABC777,       7'd13, 1'b0, 2'd0}
   };

   initial begin
      int rd0, wr0;
      string tg;
      for (int i = 0; i < 1024; i++) mem[i] = '0;
      mem[0]  = 64'h8000_0000_0000_0106;   // directory -> 0x100, 6 bits
      mem[1]  = 64'hC000_1234_5678_0000;   // leaf, page 19 bits
      mem[3]  = 64'h8000_0000_0000_0314;   // directory with 20 bits (too wide)
      mem[32] = 64'hC000_0000_00AB_C000;   // leaf, flags clear
      mem[34] = 64'hC000_0000_0555_0180;   // leaf, reference+change set
      mem[35] = 64'h8000_0000_0000_0204;   // directory with 4 bits
      for (int k = 0; k < 8; k++)
         mem[(12'h800 + 12'h100*k) >> 3] = 64'h8000_0000_0000_0005 | 64'(12'h900 + 12'h100*k);

      repeat (3) @(negedge clk);
      chk("R1 reset done", {63'd0, done}, 64'd0);
      chk("R1 reset req", {63'd0, mem_req}, 64'd0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 idle fault", {63'd0, fault}, 64'd0);

      for (int v = 0; v < 10; v++) begin
         rd0 = nrd; wr0 = nwr;
         walk(64'h0, 5'd5, 7'd24, VT[v].ea, VT[v].st);
         tg = VT[v].flt ? (VT[v].cs[0] ? "R3 cfg fault" : "R4 no entry") : "R6 leaf";
         chk(tg, {63'd0, fault}, {63'd0, VT[v].flt});
         chk(tg, {62'd0, cause}, {62'd0, VT[v].cs});
         if (!VT[v].flt) begin
            chk("R6 raddr", raddr, VT[v].ra);
            chk("R6 page_bits", {57'd0, page_bits}, {57'd0, VT[v].pg});
            chk("R7 wr_ok", {63'd0, wr_ok}, {63'd0, VT[v].wok});
         end
         chk("R8 write count", 64'(nwr - wr0), 64'(VT[v].nw));
         @(negedge clk);
         chk("R1 done one cycle", {63'd0, done}, 64'd0);
      end
      chk("R7 flags in image", mem[32], 64'hC000_0000_00AB_C180);
      chk("R7 ref only on load", mem[1], 64'hC000_1234_5678_0100);

      walk(64'h0, 5'd5, 7'd24, 64'h4ABC, 1'b0);
      chk("R2 leaf fetch address", last_rd, 64'h110);
      walk(64'h0, 5'd5, 7'd24, 64'h0ABCDE, 1'b0);
      chk("R2 top fetch address", last_rd, 64'h008);

      rd0 = nrd;
      walk(64'h0, 5'd4, 7'd24, 64'h123, 1'b0);
      chk("R3 narrow top cause", {62'd0, cause}, 64'd1);
      chk("R3 no read", 64'(nrd - rd0), 64'd0);
      walk(64'h0, 5'd25, 7'd24, 64'h123, 1'b0);
      chk("R3 wide top cause", {62'd0, cause}, 64'd1);

      rd0 = nrd;
      walk(64'h800, 5'd5, 7'd64, 64'hABCDEF, 1'b0);
      chk("R9 depth fault", {62'd0, cause}, 64'd1);
      chk("R9 reads", 64'(nrd - rd0), 64'd8);
      mem[12'hF00 >> 3] = 64'hC000_7700_0000_0000;
      rd0 = nrd; wr0 = nwr;
      walk(64'h800, 5'd5, 7'd64, 64'hABCDEF, 1'b1);
      chk("R9 eighth level leaf", {63'd0, fault}, 64'd0);
      chk("R5 page after 8 levels", {57'd0, page_bits}, 64'd24);
      chk("R6 deep raddr", raddr, 64'h0000_7700_00AB_CDEF);
      chk("R9 deep reads", 64'(nrd - rd0), 64'd8);
      chk("R8 deep write", 64'(nwr - wr0), 64'd1);
      chk("R7 deep image", mem[12'hF00 >> 3], 64'hC000_7700_0000_0180);

      @(negedge clk);
      ea = 64'h123; is_store = 1'b0; root_base = 64'h0; root_idx_bits = 5'd5; total_bits = 7'd24;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      @(negedge clk);
      ea = 64'h0ABCDE; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      for (int n = 0; n < 1000 && !done; n++) @(negedge clk);
      chk("R1 start ignored while busy", raddr, 64'hABC123);

      chk("R10 request steady", 64'(viol), 64'd0);

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule